// File: doc/BRIEF.md
# Interrupt Request Capture with Per-Line Trigger Select

This block turns a set of raw interrupt input lines into a vector of pending requests. Every line is sampled once per clock. A trigger-select register decides, line by line, whether that line is captured on its rising edge or simply follows its input level. Each line keeps a one-bit copy of its previous sample, called edge memory, and compares the new sample against it to find a rising edge.

Software loads the trigger-select register through a write port. Only the bits enabled by a fixed, per-instance writable-bit mask can change. Fixed bits always read back as zero, so those lines stay edge captured. An acknowledge strobe with a line index removes a captured edge request. A level request ignores the acknowledge and stays pending for as long as its input stays high. An init strobe returns pending, edge-memory and select state to zero. The writable-bit mask is a parameter, so reset and init leave it unchanged.

Priority resolution, masking and vector generation sit downstream and take the pending vector from this block.

Top module: `irq_trig_capture`

## Requirements
- R1: A line whose select bit is 1 (level mode) shows its input sample on its pending bit one clock later, both set and clear, and an acknowledge has no effect on it.
- R2: A line whose select bit is 0 (edge mode) sets its pending bit one clock after a sample that is high when the previous sample was low. A line held high after its request was acknowledged does not set its pending bit again.
- R3: In edge mode, a high-to-low change of the input leaves the pending bit unchanged.
- R4: A valid acknowledge with index k clears pending bit k one clock later when line k is in edge mode. When line k is in level mode, the acknowledge has no effect.
- R5: When an acknowledge for an edge-mode line arrives in the same cycle as a new rising edge on that line, the pending bit stays set.
- R6: A select write stores the write data ANDed with the instance's writable-bit mask. The stored value reads back on `trig_sel_rdata` one clock later, and masked bits read as 0.
- R7: An init strobe clears pending, edge memory and select state one clock later and wins over a select write in the same cycle. Because edge memory is cleared, an edge-mode input still high after init is captured as a new request.
- R8: After reset, the pending vector and the select readback are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_in | input | NUM_LINES | Raw interrupt input levels |
| trig_sel_we | input | 1 | Write strobe for the trigger-select register |
| trig_sel_wdata | input | NUM_LINES | Select write data, 1 = level, 0 = edge |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_line | input | IDX_W | Index of the acknowledged line |
| init_clr | input | 1 | Clears pending, edge memory and select state |
| pending | output | NUM_LINES | Pending-request vector |
| trig_sel_rdata | output | NUM_LINES | Trigger-select register readback |

## Verification
The hardest case to reach from the ports is an acknowledge that lands in the same cycle as a fresh rising edge on the same edge-mode line. To get there, the bench first captures an edge on the line, then drops the input for one cycle so that edge memory is cleared while the request stays pending. It then raises the input and acknowledges the line in a single cycle. A second hard case is an input still high across an init strobe. After init, that input must read as a new edge, and the bench holds it high through the strobe to check this.

// File: rtl/irq_cap_pkg.sv
package irq_cap_pkg;
  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_mode_e;
endpackage

// File: rtl/irq_trig_sel_reg.sv
module irq_trig_sel_reg #(
  parameter int                   NUM_LINES = 8,
  parameter logic [NUM_LINES-1:0] WR_MASK   = 8'hF8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [NUM_LINES-1:0] wr_data,
  input  logic                 init_clr,
  output logic [NUM_LINES-1:0] sel_q
);
  logic [NUM_LINES-1:0] sel_d;
  logic                 sel_en;

  always_comb begin
    sel_en = init_clr | wr_en;
    if (init_clr) sel_d = '0;
    else          sel_d = wr_data & WR_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_en) sel_q <= sel_d;
  end

  AST_SEL_MASKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !init_clr) |=> (sel_q == ($past(wr_data) & WR_MASK))); // R6
  AST_SEL_FIXED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((sel_q & ~WR_MASK) == '0)); // R6
  AST_SEL_INIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    init_clr |=> (sel_q == '0)); // R7
endmodule

// File: rtl/irq_line_cell.sv
module irq_line_cell
  import irq_cap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  trig_mode_e mode,
  input  logic       req,
  input  logic       ack_hit,
  input  logic       init_clr,
  output logic       pend_o
);
  logic pend_q, pend_d;
  logic mem_q, mem_d;
  logic rise;

  always_comb begin
    rise = req & ~mem_q;
    if (init_clr) begin
      pend_d = 1'b0;
      mem_d  = 1'b0;
    end else if (mode == TRIG_LEVEL) begin
      pend_d = req;
      mem_d  = req;
    end else begin
      mem_d = req;
      if (rise)         pend_d = 1'b1;
      else if (ack_hit) pend_d = 1'b0;
      else              pend_d = pend_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      mem_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      mem_q  <= mem_d;
    end
  end

  assign pend_o = pend_q;

  AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TRIG_LEVEL && !init_clr) |=> (pend_o == $past(req))); // R1
  AST_EDGE_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TRIG_EDGE && !init_clr && mem_q && !pend_q) |=> !pend_o); // R2
  AST_EDGE_FALL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TRIG_EDGE && !init_clr && !ack_hit && pend_q) |=> pend_o); // R3
  AST_ACK_CLEARS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TRIG_EDGE && !init_clr && ack_hit && !(req && !mem_q)) |=> !pend_o); // R4
  AST_ACK_EDGE_RACE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TRIG_EDGE && !init_clr && ack_hit && req && !mem_q) |=> pend_o); // R5
  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    init_clr |=> (!pend_o && !mem_q)); // R7
endmodule

// File: rtl/irq_trig_capture.sv
module irq_trig_capture
  import irq_cap_pkg::*;
#(
  parameter int                   NUM_LINES   = 8,
  parameter logic [NUM_LINES-1:0] SEL_WR_MASK = 8'hF8,
  localparam int                  IDX_W       = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] req_in,
  input  logic                 trig_sel_we,
  input  logic [NUM_LINES-1:0] trig_sel_wdata,
  input  logic                 ack_valid,
  input  logic [IDX_W-1:0]     ack_line,
  input  logic                 init_clr,
  output logic [NUM_LINES-1:0] pending,
  output logic [NUM_LINES-1:0] trig_sel_rdata
);
  logic [NUM_LINES-1:0] sel_q;
  logic [NUM_LINES-1:0] ack_hit;

  irq_trig_sel_reg #(
    .NUM_LINES (NUM_LINES),
    .WR_MASK   (SEL_WR_MASK)
  ) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (trig_sel_we),
    .wr_data  (trig_sel_wdata),
    .init_clr (init_clr),
    .sel_q    (sel_q)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    trig_mode_e line_mode;
    assign line_mode  = trig_mode_e'(sel_q[i]);
    assign ack_hit[i] = ack_valid && (ack_line == IDX_W'(i));

    irq_line_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (line_mode),
      .req      (req_in[i]),
      .ack_hit  (ack_hit[i]),
      .init_clr (init_clr),
      .pend_o   (pending[i])
    );
  end

  assign trig_sel_rdata = sel_q;

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_hit)); // R4
  AST_INIT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    init_clr |=> (pending == '0 && trig_sel_rdata == '0)); // R7
endmodule

// File: tb/irq_trig_capture_bench.sv
module irq_trig_capture_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] req;
  logic         sel_we;
  logic [N-1:0] sel_wdata;
  logic         ack_v;
  logic [2:0]   ack_idx;
  logic         init;
  logic [N-1:0] pend_a, sel_a, pend_b, sel_b;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_trig_capture #(.NUM_LINES(N), .SEL_WR_MASK(8'hF8)) u_irq_trig_capture (
    .clk(clk), .rst_n(rst_n), .req_in(req), .trig_sel_we(sel_we),
    .trig_sel_wdata(sel_wdata), .ack_valid(ack_v), .ack_line(ack_idx),
    .init_clr(init), .pending(pend_a), .trig_sel_rdata(sel_a));

  irq_trig_capture #(.NUM_LINES(N), .SEL_WR_MASK(8'hDE)) u_irq_trig_capture_b (
    .clk(clk), .rst_n(rst_n), .req_in(req), .trig_sel_we(sel_we),
    .trig_sel_wdata(sel_wdata), .ack_valid(ack_v), .ack_line(ack_idx),
    .init_clr(init), .pending(pend_b), .trig_sel_rdata(sel_b));

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // inputs change at negedge; one step later the registered result is visible
  task automatic step();
    @(negedge clk);
    sel_we = 1'b0; ack_v = 1'b0; init = 1'b0;
  endtask

  task automatic write_sel(logic [N-1:0] v);
    sel_we = 1'b1; sel_wdata = v; step();
  endtask

  task automatic ack(int line);
    ack_v = 1'b1; ack_idx = 3'(line); step();
  endtask

  task automatic t_reset();
    chk("R8 pending", pend_a, 8'h00);
    chk("R8 select", sel_a, 8'h00);
  endtask

  task automatic t_select();
    write_sel(8'hFF);
    chk("R6 mask F8", sel_a, 8'hF8);
    chk("R6 mask DE", sel_b, 8'hDE);
    write_sel(8'h0F);
    chk("R6 partial", sel_a, 8'h08);
    write_sel(8'h00);
    chk("R6 clear", sel_a, 8'h00);
  endtask

  task automatic t_edge();
    req[0] = 1'b1; step();
    chk("R2 rise", pend_a, 8'h01);
    step();
    chk("R2 hold", pend_a, 8'h01);
    ack(0);
    chk("R4 ack edge", pend_a, 8'h00);
    step(); step();
    chk("R2 no rearm", pend_a, 8'h00);
    req[0] = 1'b0; step();
    req[0] = 1'b1; step();
    chk("R2 second rise", pend_a, 8'h01);
    req[0] = 1'b0; step();
    chk("R3 fall keeps", pend_a, 8'h01);
    ack(0);
    chk("R4 ack after fall", pend_a, 8'h00);
  endtask

  task automatic t_level();
    write_sel(8'h08);
    req[3] = 1'b1; step();
    chk("R1 level set", pend_a, 8'h08);
    ack(3);
    chk("R4 ack level ignored", pend_a, 8'h08);
    req[3] = 1'b0; step();
    chk("R1 level clear", pend_a, 8'h00);
    write_sel(8'h00);
  endtask

  task automatic t_race();
    req[1] = 1'b1; step();
    chk("R2 line1 rise", pend_a, 8'h02);
    req[1] = 1'b0; step();
    req[1] = 1'b1; ack_v = 1'b1; ack_idx = 3'd1; step();
    chk("R5 ack with edge", pend_a, 8'h02);
    ack(1);
    chk("R5 later ack", pend_a, 8'h00);
    req[1] = 1'b0; step();
  endtask

  task automatic t_init();
    write_sel(8'h08);
    req[2] = 1'b1; req[3] = 1'b1; step();
    chk("R7 before init", pend_a, 8'h0C);
    ack(2);
    chk("R7 line2 acked", pend_a, 8'h08);
    init = 1'b1; sel_we = 1'b1; sel_wdata = 8'hFF; step();
    chk("R7 pending cleared", pend_a, 8'h00);
    chk("R7 select cleared", sel_a, 8'h00);
    step();
    chk("R7 held line re-captured", pend_a, 8'h0C);
    req = '0; ack(2); ack(3);
    chk("R7 cleanup", pend_a, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; req = '0; sel_we = 1'b0; sel_wdata = '0;
    ack_v = 1'b0; ack_idx = '0; init = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_select();
    t_edge();
    t_level();
    t_race();
    t_init();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule